// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block connects an on-chip requester to an external asynchronous static RAM of 512K locations by 8 bits. The requester offers one transfer at a time over a valid/ready handshake: a 19-bit location, a direction flag and, for stores, one data byte. The controller then drives the memory's active-low select, write-strobe and output-enable pins in a fixed order. It steers the shared 8-bit data bus through a separate output value, an output enable and an input value. Each finished transfer produces a one-clock completion pulse, and for loads the captured byte comes with it.

Every phase length is a parameter counted in system clocks: load access clocks, write-strobe clocks and bus-turnaround clocks. The defaults suit a 100 MHz clock and the fastest memory speed grade. The memory's output enable stays high for the whole of a store, so the plain minimum strobe width applies. The location is presented one clock before the strobe falls and held one clock past its rise. The controller's data driver is released only after the write strobe has gone high again.

Top module: `asram_port`

## Requirements
- R1: While reset is low, and right after it, the select, write-strobe and output-enable pins are all high (inactive), the data driver enable is 0, ready is 1 and the completion pulse is 0.
- R2: Ready is 1 only when the controller is idle. A request is taken on a clock edge where valid and ready are both 1, and ready reads 0 in the cycle after acceptance.
- R3: A load (write flag 0) holds select and output enable low and write strobe high for RD_CLKS clocks. The completion pulse rises RD_CLKS clocks after the accepting edge.
- R4: Whenever the write strobe is low, select is low, output enable is high and the data driver is on.
- R5: A store (write flag 1) spends one clock with select low and the write strobe high, then WR_CLKS clocks with the strobe low, then one recovery clock with the strobe high and the driver still on. The completion pulse comes in that recovery clock, WR_CLKS+1 clocks after acceptance, and the driver is off in the following clock.
- R6: The memory address does not change while select stays low across consecutive clocks, including the clock after the write strobe rises.
- R7: A store whose previous accepted request was a load first waits TA_CLKS clocks with all strobes high and the driver off, so its completion comes TA_CLKS clocks later than R5. A store after a store has no such wait.
- R8: A load returns, with its completion pulse, the byte most recently stored at the same location, including the lowest (0) and highest (0x7FFFF) locations and after an overwrite.
- R9: The completion pulse lasts exactly one clock and comes exactly once per accepted request, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Memory location |
| req_wdata | input | 8 | Byte to store |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Loaded byte, valid with rsp_done after a load |
| mem_addr | output | 19 | Address pins of the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 8 | Value read from the data bus |

## Verification
A wrong sequencer state shows first on the memory pins: a write strobe falling without select, or with output enable low, is visible in the same clock. A counter off by one moves the completion pulse one clock early or late relative to the accepting edge, so the latency check catches it on the first request of that kind. A wrong capture instant or a lost address shows as a mismatched byte at the next load of that location. A missing turnaround shows as a store after a load completing one clock too soon.

// File: rtl/asram_pkg.sv
// Shared types for the asynchronous SRAM port controller.
// Assumes: pin levels are active-low strobes plus a driver enable.
package asram_pkg;

    // Sequencer states, one per bus phase
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_CAPT,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_RECOVER,
        ST_TURN
    } asram_state_e;

    // Pin levels produced for one phase
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } asram_pins_t;

    // Pin levels that belong to each phase
    function automatic asram_pins_t pins_for(asram_state_e st);
        asram_pins_t p;
        p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        case (st)
            ST_RD_WAIT:    begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            ST_WR_SETUP:   begin p.cs_n = 1'b0; end
            ST_WR_STROBE:  begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
            ST_WR_RECOVER: begin p.drv  = 1'b1; end
            default:       ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_seq.sv
// Phase sequencer: walks the load, store and turnaround phases and
// drives registered strobe pins from the next state, so pins never glitch.
// Assumes: RD_CLKS, WR_CLKS, TA_CLKS are all at least 1.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CLKS = 2,
    parameter int WR_CLKS = 1,
    parameter int TA_CLKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic done,
    output logic cs_n,
    output logic we_n,
    output logic oe_n,
    output logic drv_en
);

    localparam int MAX_CLKS = (RD_CLKS > WR_CLKS) ?
                              ((RD_CLKS > TA_CLKS) ? RD_CLKS : TA_CLKS) :
                              ((WR_CLKS > TA_CLKS) ? WR_CLKS : TA_CLKS);
    localparam int CNT_W = (MAX_CLKS < 2) ? 1 : $clog2(MAX_CLKS);

    asram_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic last_rd_q;
    asram_pins_t pins_q, pins_d;
    logic done_q;
    logic cnt_zero;

    assign cnt_zero  = (cnt_q == '0);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state_q == ST_RD_WAIT) && cnt_zero;

    // Next-state choice for each phase
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)     state_d = ST_RD_WAIT;
                    else if (last_rd_q) state_d = ST_TURN;
                    else                state_d = ST_WR_SETUP;
                end
            end
            ST_RD_WAIT:    if (cnt_zero) state_d = ST_RD_CAPT;
            ST_RD_CAPT:    state_d = ST_IDLE;
            ST_TURN:       if (cnt_zero) state_d = ST_WR_SETUP;
            ST_WR_SETUP:   state_d = ST_WR_STROBE;
            ST_WR_STROBE:  if (cnt_zero) state_d = ST_WR_RECOVER;
            ST_WR_RECOVER: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Phase length counter: loaded on entry, counts down to zero
    always_comb begin
        cnt_d = cnt_zero ? cnt_q : cnt_q - 1'b1;
        if (state_d != state_q) begin
            case (state_d)
                ST_RD_WAIT:   cnt_d = CNT_W'(RD_CLKS - 1);
                ST_WR_STROBE: cnt_d = CNT_W'(WR_CLKS - 1);
                ST_TURN:      cnt_d = CNT_W'(TA_CLKS - 1);
                default:      cnt_d = '0;
            endcase
        end
    end

    assign pins_d = pins_for(state_d);

    // State, counter, last-direction and registered pin update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            last_rd_q <= 1'b0;
            pins_q    <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) last_rd_q <= !req_write;
            pins_q  <= pins_d;
            done_q  <= (state_d == ST_RD_CAPT) || (state_d == ST_WR_RECOVER);
        end
    end

    assign cs_n   = pins_q.cs_n;
    assign we_n   = pins_q.we_n;
    assign oe_n   = pins_q.oe_n;
    assign drv_en = pins_q.drv;
    assign done   = done_q;

    // R1: reset forces all strobes inactive and the driver off
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (cs_n && we_n && oe_n && !drv_en && !done));

    // R4: output enable high and select low whenever the strobe is low
    a_r4_strobe_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !cs_n && drv_en));

    // R2: while ready, the bus is quiet
    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (we_n && oe_n && !drv_en));

    // R9: completion lasts a single clock
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: the read phase ends with a capture and a completion
    a_r3_capture_done: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (done && cs_n && oe_n));

endmodule

// File: rtl/asram_dpath.sv
// Data path: holds the location and store byte from acceptance until
// the next acceptance, and captures the load byte on the capture strobe.
// Assumes: accept only occurs while the sequencer is idle.
module asram_dpath #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic [DW-1:0] rd_data
);

    // Request registers, loaded only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Load byte capture at the end of the access count
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= mem_dq_i;
    end

endmodule

// File: rtl/asram_port.sv
// Top of the asynchronous SRAM port controller: a sequencer for the
// strobes and a data path for address and data, wired to the memory pins.
// Assumes: one request at a time; phase lengths in clocks fit the memory grade.
module asram_port #(
    parameter int AW      = 19,
    parameter int DW      = 8,
    parameter int RD_CLKS = 2,
    parameter int WR_CLKS = 1,
    parameter int TA_CLKS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    logic accept;
    logic capture;

    asram_seq #(
        .RD_CLKS(RD_CLKS),
        .WR_CLKS(WR_CLKS),
        .TA_CLKS(TA_CLKS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .done     (rsp_done),
        .cs_n     (mem_cs_n),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n),
        .drv_en   (mem_dq_oe)
    );

    asram_dpath #(
        .AW(AW),
        .DW(DW)
    ) dpath_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .capture  (capture),
        .mem_dq_i (mem_dq_i),
        .mem_addr (mem_addr),
        .mem_dq_o (mem_dq_o),
        .rd_data  (rsp_rdata)
    );

    // R6: address holds while select stays low
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n) |=> $stable(mem_addr));

    // R5: driver still on in the clock the strobe rises
    a_r5_drv_on_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R5: driver released one clock after the strobe rises
    a_r5_drv_off_after: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> !mem_dq_oe);

    // R4: the memory never drives while the controller drives
    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

endmodule

// File: tb/asram_port_tb.sv
// Scoreboard bench: the issue task queues expected completions; a monitor
// pops them on each completion pulse and checks latency and data.
module asram_port_tb_top;

    localparam int AW = 19;
    localparam int DW = 8;
    localparam int RD = 2;
    localparam int WR = 1;
    localparam int TA = 1;

    typedef struct {
        bit          is_rd;
        logic [7:0]  data;
        int          lat;
        int          acc;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r9 = 0, v_r9q = 0;
    bit last_rd = 1'b0;
    exp_t sb[$];
    logic [7:0] model_mem [int unsigned];
    logic [7:0] ref_mem   [int unsigned];

    asram_port dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    // Behavioural memory: store while select and strobe are both low
    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe)
            model_mem[int'(mem_addr)] = mem_dq_o;
    end

    // Behavioural memory: drive bus on select low, output enable low, strobe high
    always_comb begin
        mem_dq_i = 8'hEE;
        if (!mem_cs_n && !mem_oe_n && mem_we_n && model_mem.exists(int'(mem_addr)))
            mem_dq_i = model_mem[int'(mem_addr)];
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pin-sequence monitor at the falling edge
    logic          p_cs_low = 1'b0;
    logic          p_we_high = 1'b1;
    logic          p_done = 1'b0;
    logic [AW-1:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && (!mem_oe_n || mem_cs_n || !mem_dq_oe)) v_r4++;
            if (mem_dq_oe && !mem_oe_n) v_r4++;
            if (mem_dq_oe && mem_we_n && p_we_high) v_r5++;
            if (p_cs_low && !mem_cs_n && mem_addr != p_addr) v_r6++;
            if (p_done && rsp_done) v_r9++;
        end
        p_cs_low  = rst_n && !mem_cs_n;
        p_we_high = !rst_n || mem_we_n;
        p_done    = rst_n && rsp_done;
        p_addr    = mem_addr;
    end

    // Scoreboard monitor: pop and compare at each completion
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (sb.size() == 0) begin
                v_r9q++;
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc - e.acc == e.lat, e.is_rd ? "R3" : (e.lat == WR + 1 + TA ? "R7" : "R5"),
                    "completion latency", cyc - e.acc, e.lat);
                if (e.is_rd)
                    chk(rsp_rdata == e.data, "R8", "load data", int'(rsp_rdata), int'(e.data));
            end
        end
    end

    // Driver: offer one request and queue what it must produce
    task automatic issue(bit w, logic [AW-1:0] a, logic [7:0] d);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        e.is_rd = !w;
        e.acc   = cyc + 1;
        e.lat   = w ? (last_rd ? WR + 1 + TA : WR + 1) : RD;
        e.data  = 8'h00;
        if (w) ref_mem[int'(a)] = d;
        else   e.data = ref_mem[int'(a)];
        sb.push_back(e);
        last_rd = !w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
    endtask

    task automatic pin_idle(string tag);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
            tag, "strobes and driver", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        chk(req_ready && !rsp_done, tag, "ready and done", {req_ready, rsp_done}, 2'b10);
    endtask

    logic [AW-1:0] pool [8];

    initial begin
        repeat (3) @(negedge clk);
        pin_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        pin_idle("R1");

        issue(1'b1, 19'h00000, 8'hA5);
        issue(1'b1, 19'h7FFFF, 8'h3C);
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b1, 19'h00010, 8'h5A);   // R7 store after load
        issue(1'b0, 19'h7FFFF, 8'h00);
        issue(1'b0, 19'h00010, 8'h00);
        issue(1'b1, 19'h00000, 8'hFF);   // R8 overwrite
        issue(1'b0, 19'h00000, 8'h00);

        for (int i = 0; i < 8; i++) pool[i] = 19'($urandom());
        for (int i = 0; i < 40; i++) begin
            int k;
            k = int'($urandom_range(7, 0));
            if ($urandom_range(1, 0) == 1 && ref_mem.exists(int'(pool[k])))
                issue(1'b0, pool[k], 8'h00);
            else
                issue(1'b1, pool[k], 8'($urandom()));
        end

        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R9", "completions outstanding", sb.size(), 0);
        chk(v_r9 == 0 && v_r9q == 0, "R9", "extra or long completions", v_r9 + v_r9q, 0);
        chk(v_r4 == 0, "R4", "strobe pin violations", v_r4, 0);
        chk(v_r5 == 0, "R5", "driver release violations", v_r5, 0);
        chk(v_r6 == 0, "R6", "address hold violations", v_r6, 0);
        pin_idle("R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule